// File: doc/BRIEF.md
# Removable-Card Host Command and Interrupt Core

This block is the register-side control core of a host for a serial removable card. A CPU reaches it through a simple word-addressed register bus. Software fills or drains an 8-byte data FIFO and starts a transfer by writing a command word. The block then raises a start pulse toward a serial engine and holds a busy level until the engine reports that it is done. The engine moves data through a byte port on the same FIFO.

Two interrupt sources are kept apart. The protocol-end source fires when the engine finishes. The card-interrupt source fires when the card's own INT line rises, which can happen some time after the transfer is over. A third status source, the data request, is a live level that tells software when the FIFO needs servicing. A soft reset triggered from the system register aborts the transfer and empties the FIFO. It leaves the clock divider, the latched interrupt sources, the INT line sample and the mask untouched. The synchronous bus reset clears everything.

Register map (word index on `bus_addr`): 0 system, 1 command, 2 data, 3 status, 4 interrupt status, 5 mask set, 6 mask clear, 7 mask read, 8 interrupt clear. All unlisted bits read as 0.

Top module: `cardhost_ctl`

## Requirements
- R1: After `rst_n` is low at a clock edge, every register reads 0 except status, which reads 1 (FIFO empty bit 0 = 1, full bit 1 = 0), and `irq` is 0.
- R2: Writing the system register with bit 15 set makes bit 15 read 1 and `eng_abort` 1 for one cycle. The following edge clears busy, empties the FIFO and clears the FIFO direction bit (system bit 8). The clock divider (system bits 7:0), interrupt status bits 0 and 1, the INT line sample (status bit 3) and the mask are kept.
- R3: Writing the command register while idle starts a protocol. The code is in bits 19:16 and the size in bits SIZE_W-1:0. After that edge, busy (status bit 2) and `eng_busy` are 1, `eng_start` is 1 for exactly one cycle, and `eng_code`/`eng_size` hold the written values.
- R4: When a protocol starts, code bit 3 is copied to the FIFO direction bit (system bit 8; 1 = toward the card, 0 = from the card), and `eng_dir` equals it.
- R5: A command write while busy is ignored: the code, size and start pulse do not change.
- R6: `eng_done` while busy clears busy and sets interrupt status bit 0 (protocol end). Writing 1 to bit 0 of the interrupt clear register clears it.
- R7: Status bit 3 follows `card_int` one cycle late. A rising edge of `card_int` sets interrupt status bit 1, which stays set after the line falls until 1 is written to bit 1 of the interrupt clear register.
- R8: Writing 1s to the mask set register sets mask bits, and writing 1s to the mask clear register clears them. The mask read register returns the mask, and `irq` is high exactly when some interrupt status bit and its mask bit are both 1.
- R9: The FIFO holds 8 bytes. A data write is accepted only when the direction bit is 1 and at least 4 bytes are free. A data read is accepted only when the direction bit is 0 and at least 4 bytes are held; it returns them with the oldest byte in bits 7:0. Refused reads return 0, and refused accesses change nothing.
- R10: Interrupt status bit 2 (data request) is 1 exactly when busy and either the direction is 1 with the FIFO empty, or the direction is 0 with the FIFO full.
- R11: `eng_rd_data` shows the oldest FIFO byte. `eng_rd` removes it only when the direction is 1 and the FIFO is not empty. `eng_wr` adds `eng_wr_data` only when the direction is 0 and the FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO on the data register) |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| clk_div | output | 8 | Serial clock divider setting |
| eng_start | output | 1 | One-cycle protocol start pulse |
| eng_busy | output | 1 | Protocol in progress |
| eng_abort | output | 1 | Soft reset in progress; engine must drop the transfer |
| eng_dir | output | 1 | Transfer direction, 1 toward the card |
| eng_code | output | 4 | Transfer protocol command code |
| eng_size | output | SIZE_W | Transfer size |
| eng_done | input | 1 | Engine reports protocol end |
| eng_rd_data | output | 8 | Oldest FIFO byte |
| eng_rd | input | 1 | Engine takes one byte |
| eng_wr | input | 1 | Engine stores one byte |
| eng_wr_data | input | 8 | Byte from the engine |
| card_int | input | 1 | Card's interrupt line |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its defaults: an 8-byte FIFO behind a 32-bit data register, a 10-bit size field and a 4-bit address. With these values two word writes fill the FIFO, so full, empty, refused third word and half-full states all occur within a few accesses. Random mixes of word and byte traffic in both directions walk the pointers across the wrap point, against a byte-queue model. Directed passes cover the direction override at start, the ignored command while busy, the separate card-interrupt latch and the selective soft reset.

// File: rtl/cardhost_pkg.sv
// Shared constants and types for the card host control core.
// Assumes a 32-bit register bus addressed by word index.
package cardhost_pkg;
    localparam int BUS_W      = 32;
    localparam int WORD_BYTES = BUS_W / 8;
    localparam int CODE_W     = 4;

    // Register word indices
    localparam int REG_SYS  = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_DATA = 2;
    localparam int REG_STAT = 3;
    localparam int REG_ISR  = 4;
    localparam int REG_IEN  = 5;
    localparam int REG_IDIS = 6;
    localparam int REG_IMSK = 7;
    localparam int REG_ICLR = 8;

    // Bit positions
    localparam int SYS_DIR   = 8;
    localparam int SYS_SRST  = 15;
    localparam int CMD_CODE  = 16;
    localparam int ISR_PEND  = 0;
    localparam int ISR_CINT  = 1;
    localparam int ISR_DRQ   = 2;
    localparam int NUM_SRC   = 3;

    typedef struct packed {
        logic drq;
        logic cint;
        logic pend;
    } isr_t;
endpackage

// File: rtl/cardhost_fifo.sv
// Byte FIFO with a word-wide CPU side and a byte-wide engine side.
// Assumes DEPTH is a power of two, not below WB, and at most one pusher and
// one popper per cycle (the caller gates by direction). clr empties it.
module cardhost_fifo #(
    parameter int DEPTH = 8,
    parameter int WB    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cpu_push,
    input  logic [8*WB-1:0] cpu_wdata,
    input  logic            cpu_pop,
    input  logic            eng_push,
    input  logic [7:0]      eng_wdata,
    input  logic            eng_pop,
    output logic [8*WB-1:0] cpu_rdata,
    output logic            cpu_pop_ok,
    output logic [7:0]      head,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt, push_n, pop_n;
    logic [PTR_W-1:0] wr_idx [WB];
    logic [PTR_W-1:0] rd_idx [WB];
    logic             cpu_push_ok, eng_push_ok, eng_pop_ok;

    // Lane indices and the word view of the oldest WB bytes
    for (genvar g = 0; g < WB; g++) begin : g_lane
        assign wr_idx[g] = wptr + PTR_W'(g);
        assign rd_idx[g] = rptr + PTR_W'(g);
        assign cpu_rdata[8*g +: 8] = mem[rd_idx[g]];
    end

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign head  = mem[rptr];

    // Acceptance of each access against the state before the edge
    always_comb begin
        cpu_push_ok = cpu_push && !clr && (cnt <= CNT_W'(DEPTH - WB));
        eng_push_ok = eng_push && !clr && !full && !cpu_push_ok;
        cpu_pop_ok  = cpu_pop  && !clr && (cnt >= CNT_W'(WB));
        eng_pop_ok  = eng_pop  && !clr && !empty && !cpu_pop_ok;
        push_n = cpu_push_ok ? CNT_W'(WB) : (eng_push_ok ? CNT_W'(1) : '0);
        pop_n  = cpu_pop_ok  ? CNT_W'(WB) : (eng_pop_ok  ? CNT_W'(1) : '0);
    end

    // Storage, pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (cpu_push_ok) begin
                for (int i = 0; i < WB; i++) mem[wr_idx[i]] <= cpu_wdata[8*i +: 8];
            end else if (eng_push_ok) begin
                mem[wptr] <= eng_wdata;
            end
            wptr <= wptr + PTR_W'(push_n);
            rptr <= rptr + PTR_W'(pop_n);
            cnt  <= cnt + push_n - pop_n;
        end
    end
endmodule

// File: rtl/cardhost_seq.sv
// Protocol sequencer: latches a command, raises start and busy, tracks the
// FIFO direction bit and reports a qualified end event.
// Assumes the engine pulses eng_done only while busy; stray pulses are dropped.
module cardhost_seq #(
    parameter int SIZE_W = 10,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              cmd_we,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              dir_we,
    input  logic              dir_val,
    input  logic              eng_done,
    output logic              busy,
    output logic              start,
    output logic              fdir,
    output logic [CODE_W-1:0] code,
    output logic [SIZE_W-1:0] size,
    output logic              done_evt
);
    logic accept;

    assign accept   = cmd_we && !busy && !soft_clr;
    assign done_evt = eng_done && busy && !soft_clr;

    // Command latch, start pulse, busy level and direction bit
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            busy  <= 1'b0;
            start <= 1'b0;
            fdir  <= 1'b0;
            code  <= '0;
            size  <= '0;
        end else begin
            start <= accept;
            if (accept) begin
                busy <= 1'b1;
                code <= cmd_code;
                size <= cmd_size;
                fdir <= cmd_code[CODE_W-1];
            end else begin
                if (eng_done) busy <= 1'b0;
                if (dir_we)   fdir <= dir_val;
            end
        end
    end
endmodule

// File: rtl/cardhost_irq.sv
// Interrupt status, mask and request logic. Only the bus reset clears it;
// the soft reset leaves the latched sources, line sample and mask intact.
// Assumes drq is a live level computed by the caller.
module cardhost_irq import cardhost_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_evt,
    input  logic               card_int,
    input  logic               drq,
    input  logic               clr_we,
    input  logic               en_we,
    input  logic               dis_we,
    input  logic [NUM_SRC-1:0] wbits,
    output isr_t               isr,
    output logic [NUM_SRC-1:0] imr,
    output logic               ista,
    output logic               irq
);
    logic pend_q, cint_q;
    logic [NUM_SRC-1:0] clr_m;

    assign clr_m = clr_we ? wbits : '0;

    // Line sample, latched sources (set wins over clear) and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ista   <= 1'b0;
            pend_q <= 1'b0;
            cint_q <= 1'b0;
            imr    <= '0;
        end else begin
            ista   <= card_int;
            pend_q <= done_evt || (pend_q && !clr_m[ISR_PEND]);
            cint_q <= (card_int && !ista) || (cint_q && !clr_m[ISR_CINT]);
            imr    <= (imr | (en_we ? wbits : '0)) & ~(dis_we ? wbits : '0);
        end
    end

    // Status vector and masked request
    always_comb begin
        isr.pend = pend_q;
        isr.cint = cint_q;
        isr.drq  = drq;
        irq      = |(isr & imr);
    end
endmodule

// File: rtl/cardhost_ctl.sv
// Card host control core top: register decode, system register, soft reset
// sequencing and read multiplexer around the sequencer, FIFO and interrupts.
// Assumes reads have no wait states; rdata is valid in the strobe cycle.
module cardhost_ctl import cardhost_pkg::*; #(
    parameter int SIZE_W     = 10,
    parameter int FIFO_BYTES = 8,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        clk_div,
    output logic              eng_start,
    output logic              eng_busy,
    output logic              eng_abort,
    output logic              eng_dir,
    output logic [3:0]        eng_code,
    output logic [SIZE_W-1:0] eng_size,
    input  logic              eng_done,
    output logic [7:0]        eng_rd_data,
    input  logic              eng_rd,
    input  logic              eng_wr,
    input  logic [7:0]        eng_wr_data,
    input  logic              card_int,
    output logic              irq
);
    logic sel_sys, sel_cmd, sel_data, sel_stat, sel_isr;
    logic sel_ien, sel_idis, sel_imsk, sel_iclr;
    logic sys_we, cmd_we, srst_q, fdir, done_evt, drq, ista;
    logic fifo_empty, fifo_full, cpu_pop_ok;
    logic [BUS_W-1:0] fifo_word;
    logic [NUM_SRC-1:0] imr_q;
    isr_t isr_q;

    // Address decode
    always_comb begin
        sel_sys  = bus_addr == ADDR_W'(REG_SYS);
        sel_cmd  = bus_addr == ADDR_W'(REG_CMD);
        sel_data = bus_addr == ADDR_W'(REG_DATA);
        sel_stat = bus_addr == ADDR_W'(REG_STAT);
        sel_isr  = bus_addr == ADDR_W'(REG_ISR);
        sel_ien  = bus_addr == ADDR_W'(REG_IEN);
        sel_idis = bus_addr == ADDR_W'(REG_IDIS);
        sel_imsk = bus_addr == ADDR_W'(REG_IMSK);
        sel_iclr = bus_addr == ADDR_W'(REG_ICLR);
        sys_we   = bus_wr && sel_sys;
        cmd_we   = bus_wr && sel_cmd;
    end

    // Self-clearing soft reset flag and clock divider field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            clk_div <= '0;
        end else begin
            srst_q <= !srst_q && sys_we && bus_wdata[SYS_SRST];
            if (sys_we) clk_div <= bus_wdata[7:0];
        end
    end

    assign eng_abort = srst_q;
    assign eng_dir   = fdir;

    cardhost_seq #(.SIZE_W(SIZE_W), .CODE_W(CODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_clr(srst_q),
        .cmd_we(cmd_we),
        .cmd_code(bus_wdata[CMD_CODE +: CODE_W]),
        .cmd_size(bus_wdata[SIZE_W-1:0]),
        .dir_we(sys_we), .dir_val(bus_wdata[SYS_DIR]),
        .eng_done(eng_done),
        .busy(eng_busy), .start(eng_start), .fdir(fdir),
        .code(eng_code), .size(eng_size), .done_evt(done_evt)
    );

    cardhost_fifo #(.DEPTH(FIFO_BYTES), .WB(WORD_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(srst_q),
        .cpu_push(bus_wr && sel_data && fdir), .cpu_wdata(bus_wdata),
        .cpu_pop(bus_rd && sel_data && !fdir),
        .eng_push(eng_wr && !fdir), .eng_wdata(eng_wr_data),
        .eng_pop(eng_rd && fdir),
        .cpu_rdata(fifo_word), .cpu_pop_ok(cpu_pop_ok),
        .head(eng_rd_data), .empty(fifo_empty), .full(fifo_full)
    );

    assign drq = eng_busy && (fdir ? fifo_empty : fifo_full);

    cardhost_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .card_int(card_int),
        .drq(drq),
        .clr_we(bus_wr && sel_iclr), .en_we(bus_wr && sel_ien),
        .dis_we(bus_wr && sel_idis), .wbits(bus_wdata[NUM_SRC-1:0]),
        .isr(isr_q), .imr(imr_q), .ista(ista), .irq(irq)
    );

    // Read multiplexer; unlisted bits and registers read 0
    always_comb begin
        bus_rdata = '0;
        if (sel_sys) begin
            bus_rdata[7:0]      = clk_div;
            bus_rdata[SYS_DIR]  = fdir;
            bus_rdata[SYS_SRST] = srst_q;
        end else if (sel_cmd) begin
            bus_rdata[CMD_CODE +: CODE_W] = eng_code;
            bus_rdata[SIZE_W-1:0]         = eng_size;
        end else if (sel_data) begin
            bus_rdata = cpu_pop_ok ? fifo_word : '0;
        end else if (sel_stat) begin
            bus_rdata[3:0] = {ista, eng_busy, fifo_full, fifo_empty};
        end else if (sel_isr) begin
            bus_rdata[NUM_SRC-1:0] = isr_q;
        end else if (sel_imsk) begin
            bus_rdata[NUM_SRC-1:0] = imr_q;
        end
    end
endmodule

// File: rtl/cardhost_chk.sv
// Property checker for cardhost_ctl, attached by bind below.
module cardhost_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       start,
    input logic       abort,
    input logic       done,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       pend,
    input logic       cmd_we,
    input logic [3:0] code,
    input logic [2:0] imr,
    input logic       irq
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start);
    // R2
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && fifo_empty));
    // R9
    fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));
    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy && !abort) |=> pend);
    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy && !abort) |=> $stable(code));
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imr == 3'b000) |-> !irq);
endmodule

bind cardhost_ctl cardhost_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .start(eng_start),
    .abort(eng_abort), .done(eng_done), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .pend(isr_q.pend), .cmd_we(cmd_we),
    .code(eng_code), .imr(imr_q), .irq(irq)
);

// File: tb/sim_cardhost_ctl.sv
// Self-checking bench: directed corner cases plus seeded random FIFO traffic
// against a byte-queue model. All tasks start and end at a falling edge.
module sim_cardhost_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  clk_div, eng_rd_data, eng_wr_data = '0;
    logic        eng_start, eng_busy, eng_abort, eng_dir, irq;
    logic [3:0]  eng_code;
    logic [9:0]  eng_size;
    logic        eng_done = 1'b0, eng_rd = 1'b0, eng_wr = 1'b0, card_int = 1'b0;
    int          n_chk = 0, n_fail = 0;
    logic [7:0]  q[$];

    always #2 clk = ~clk;

    cardhost_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_div(clk_div), .eng_start(eng_start), .eng_busy(eng_busy),
        .eng_abort(eng_abort), .eng_dir(eng_dir), .eng_code(eng_code),
        .eng_size(eng_size), .eng_done(eng_done), .eng_rd_data(eng_rd_data),
        .eng_rd(eng_rd), .eng_wr(eng_wr), .eng_wr_data(eng_wr_data),
        .card_int(card_int), .irq(irq)
    );

    function automatic logic [31:0] stat_word(int cnt, bit busy, bit ista);
        return {28'd0, ista, busy, cnt == 8, cnt == 0};
    endfunction

    function automatic logic [31:0] cmd_word(logic [3:0] code, logic [9:0] size);
        return {12'd0, code, 6'd0, size};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rchk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic epush(input logic [7:0] b);
        eng_wr = 1'b1; eng_wr_data = b;
        @(negedge clk);
        eng_wr = 1'b0;
    endtask

    task automatic epop(output logic [7:0] b);
        eng_rd = 1'b1;
        #1 b = eng_rd_data;
        @(negedge clk);
        eng_rd = 1'b0;
    endtask

    task automatic pulse_done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] d, w;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 sys", 0, 0);
        rchk("R1 stat", 3, stat_word(0, 0, 0));
        rchk("R1 isr", 4, 0);
        rchk("R1 imr", 7, 0);
        chk("R1 irq", 32'(irq), 0);

        // R8 mask set / clear
        wr(5, 32'h7);
        wr(6, 32'h4);
        rchk("R8 imr", 7, 32'h3);
        chk("R8 irq idle", 32'(irq), 0);

        // R3/R4 write-direction command
        wr(1, cmd_word(4'hB, 10'd8));
        chk("R3 start", 32'(eng_start), 1);
        chk("R3 code", 32'(eng_code), 32'hB);
        chk("R3 size", 32'(eng_size), 8);
        chk("R4 eng_dir", 32'(eng_dir), 1);
        rchk("R4 sys dir", 0, 32'h100);
        chk("R3 start one cycle", 32'(eng_start), 0);
        rchk("R3 busy", 3, stat_word(0, 1, 0));
        rchk("R10 drq write empty", 4, 32'h4);

        // R5 ignored while busy
        wr(1, cmd_word(4'h2, 10'd3));
        chk("R5 code kept", 32'(eng_code), 32'hB);
        chk("R5 size kept", 32'(eng_size), 8);
        chk("R5 no start", 32'(eng_start), 0);

        // R9/R11 CPU fills, engine drains
        wr(2, 32'h44332211);
        wr(2, 32'h88776655);
        rchk("R9 full", 3, stat_word(8, 1, 0));
        rchk("R10 drq off when full", 4, 0);
        wr(2, 32'hDEADBEEF);
        for (int i = 0; i < 8; i++) begin
            epop(b);
            chk("R11 byte order", 32'(b), 32'(8'h11 * (i + 1)));
        end
        rchk("R9 empty again", 3, stat_word(0, 1, 0));

        // R6 protocol end
        pulse_done();
        rchk("R6 pend", 4, 32'h1);
        chk("R8 irq pend", 32'(irq), 1);
        rchk("R6 idle", 3, stat_word(0, 0, 0));
        wr(8, 32'h1);
        rchk("R6 pend cleared", 4, 0);
        chk("R8 irq clear", 32'(irq), 0);

        // R4/R9/R10/R11 read-direction command
        wr(1, cmd_word(4'h2, 10'd5));
        rchk("R4 dir to 0", 0, 0);
        for (int i = 0; i < 8; i++) epush(8'hA0 + 8'(i));
        rchk("R9 full read", 3, stat_word(8, 1, 0));
        rchk("R10 drq read full", 4, 32'h4);
        epush(8'hEE);
        rchk("R9 word 0", 2, 32'hA3A2A1A0);
        rchk("R11 word 1", 2, 32'hA7A6A5A4);
        rchk("R9 empty read", 2, 0);
        rchk("R9 empty flag", 3, stat_word(0, 1, 0));
        pulse_done();
        wr(8, 32'h1);

        // R7 card interrupt
        card_int = 1'b1;
        @(negedge clk);
        rchk("R7 cint", 4, 32'h2);
        rchk("R7 ista", 3, stat_word(0, 0, 1));
        card_int = 1'b0;
        @(negedge clk);
        rchk("R7 cint held", 4, 32'h2);
        rchk("R7 ista low", 3, stat_word(0, 0, 0));
        wr(8, 32'h2);
        rchk("R7 cleared", 4, 0);

        // R2 soft reset keeps selected fields
        card_int = 1'b1;
        wr(1, cmd_word(4'h8, 10'd1));
        pulse_done();
        wr(1, cmd_word(4'h9, 10'd2));
        wr(2, 32'h01020304);
        wr(0, 32'h815A);
        chk("R2 abort", 32'(eng_abort), 1);
        rchk("R2 rst bit", 0, 32'h815A);
        rchk("R2 sys after", 0, 32'h5A);
        rchk("R2 stat after", 3, stat_word(0, 0, 1));
        rchk("R2 isr kept", 4, 32'h3);
        rchk("R2 imr kept", 7, 32'h3);
        chk("R2 clk_div", 32'(clk_div), 32'h5A);
        card_int = 1'b0;
        wr(8, 32'h3);

        // R9/R11 random toward-card traffic
        wr(0, 32'h100);
        for (int s = 0; s < 200; s++) begin
            int op = int'($urandom % 3);
            if (op == 0) begin
                w = $urandom;
                wr(2, w);
                if (q.size() <= 4) for (int k = 0; k < 4; k++) q.push_back(w[8*k +: 8]);
            end else if (op == 1) begin
                epop(b);
                if (q.size() > 0) begin
                    chk("R11 rand head", 32'(b), 32'(q[0]));
                    void'(q.pop_front());
                end
            end else begin
                @(negedge clk);
            end
            rchk("R9 rand flags", 3, stat_word(q.size(), 0, 0));
        end

        // R9/R11 random from-card traffic
        wr(0, 32'h0);
        for (int s = 0; s < 200; s++) begin
            if ($urandom % 2 == 0) begin
                b = 8'($urandom);
                epush(b);
                if (q.size() < 8) q.push_back(b);
            end else begin
                rd(2, d);
                if (q.size() >= 4) begin
                    w = {q[3], q[2], q[1], q[0]};
                    repeat (4) void'(q.pop_front());
                end else begin
                    w = 0;
                end
                chk("R9 rand word", d, w);
            end
            rchk("R11 rand flags", 3, stat_word(q.size(), 0, 0));
        end

        // R1 bus reset clears everything
        wr(0, 32'h77);
        wr(5, 32'h7);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rchk("R1 sys cleared", 0, 0);
        rchk("R1 imr cleared", 7, 0);
        rchk("R1 fifo empty", 3, stat_word(0, 0, 0));
        chk("R1 clk_div", 32'(clk_div), 0);

        summary();
        $finish;
    end
endmodule